// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Bank

This block is an eight-pin general-purpose I/O port with a small register interface. Software sets each pin's direction, writes the value the port drives, and reads either the actual pin levels or the stored drive value. The pad side gives each pin a drive value, a drive enable and a sampled input. Input levels pass through a two-stage synchronizer before a read can see them. Read data is registered, so it appears one cycle after the request.

Two functions can take pins away from digital use. The first is an analog-select register, with one bit per pin. A pin marked analog reads as zero through the pin-level register. After reset the six low pins are marked analog. The second is a configuration input that gives the two top pins to an oscillator. While it is high, those pins stop driving and their bits read as zero in the pin-level, latch and direction registers. The stored latch and direction bits are not changed, so they return when the input is released.

A writer should keep a pin's direction bit at 1 while the pin is analog, because direction still controls the driver in analog mode. Register selection: 0 = pin levels (a write updates the latch), 1 = latch, 2 = direction, 3 = analog select.

The bus sequencer has two named states:
- **BUS_IDLE**: rd_valid is low.
- **BUS_RESP**: rd_valid is high and rdata holds the data that was read.

It has three named transitions:
- **T_ISSUE** (BUS_IDLE to BUS_RESP) is taken on rd_en.
- **T_CHAIN** (BUS_RESP to BUS_RESP) is taken when rd_en is high again.
- **T_DRAIN** (BUS_RESP to BUS_IDLE) is taken when rd_en is low.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the registers hold these values: direction = 0xFF, latch = 0x00, analog select = 0x3F. All pad_oe bits are 0.
- R2: A write to selector 1 stores wdata in the latch. pad_out shows the new value from the cycle after the write, and a read of selector 1 returns it.
- R3: A write to selector 0 also updates the latch, which a read of selector 1 shows. A read of selector 0 returns the synchronized pin levels, not the latch.
- R4: A write to selector 2 stores the direction. pad_oe[i] is the inverse of direction bit i (1 = input, 0 = driving), and the change shows from the cycle after the write.
- R5: A read of selector 0 sees a pad_in change only when the read's capture edge is the third rising edge after the change, or later. A read that captures on the second edge still returns the old level.
- R6: A bit whose analog-select bit is 1 reads as 0 through selector 0.
- R7: While osc_claim is 1, bits 7:6 read as 0 through selectors 0, 1 and 2, and pad_oe[7:6] is 0.
- R8: rd_valid is 1 in exactly the cycle after rd_en is sampled high. rdata holds the selected register's value in that cycle.
- R9: A write to selector 3 stores the analog-select mask, and a read of selector 3 returns it unmasked.
- R10: Deasserting osc_claim brings back the stored latch and direction bits 7:6. The same bits come back in the readback values and in pad_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register selector |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| osc_claim | input | 1 | Hands pins 7:6 to the oscillator |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Pin drive values (latch) |
| pad_oe | output | 8 | Pin drive enables |

## Verification
The hardest case to reach from the ports is the synchronizer window. Pin-level reads must be timed to the exact edge at which the second stage takes a new level. The bench changes pad_in and then issues a read whose capture edge falls on the second rising edge after the change, expecting the old level. It then repeats the read one cycle later, when the new level should be visible. The other hard case is checking that oscillator masking leaves the stored bits intact. For this, the bench loads the latch and direction with non-zero top bits, claims the pins, confirms the reads return zero, and checks that the stored values come back on release.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_PINS  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_ANSEL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_store.sv
module gpio_reg_store
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] DIR_RST = '1,
    parameter logic [WIDTH-1:0] LAT_RST = '0,
    parameter logic [WIDTH-1:0] ANA_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] ana_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= LAT_RST;
            dir_q <= DIR_RST;
            ana_q <= ANA_RST;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PINS,
                SEL_LATCH: lat_q <= wdata;
                SEL_DIR:   dir_q <= wdata;
                SEL_ANSEL: ana_q <= wdata;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] pins_view,
    input  logic [WIDTH-1:0] lat_view,
    input  logic [WIDTH-1:0] dir_view,
    input  logic [WIDTH-1:0] ana_view,
    output logic [WIDTH-1:0] rdata,
    output logic             rd_valid
);
    bus_state_e       state_q, state_d;
    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_en ? BUS_RESP : BUS_IDLE; // T_ISSUE
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE; // T_CHAIN / T_DRAIN
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_PINS:  word_d = pins_view;
            SEL_LATCH: word_d = lat_view;
            SEL_DIR:   word_d = dir_view;
            SEL_ANSEL: word_d = ana_view;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word_q <= '0;
        else if (rd_en) word_q <= word_d;
    end

    assign rd_valid = (state_q == BUS_RESP);
    assign rdata    = rd_valid ? word_q : '0;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter int               OSC_PINS = 2,
    parameter int               SYNC_LEN = 2,
    parameter logic [WIDTH-1:0] ANA_RST  = 8'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             rd_valid,
    input  logic             osc_claim,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    localparam int LOW_PINS = WIDTH - OSC_PINS;

    reg_sel_e         sel;
    logic [WIDTH-1:0] lat_q, dir_q, ana_q, pins_sync, keep_mask;

    assign sel = reg_sel_e'(addr);

    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        if (i >= LOW_PINS) begin : g_osc
            assign keep_mask[i] = ~osc_claim;
        end else begin : g_plain
            assign keep_mask[i] = 1'b1;
        end
    end

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(pins_sync)
    );

    gpio_reg_store #(
        .WIDTH(WIDTH), .DIR_RST('1), .LAT_RST('0), .ANA_RST(ANA_RST)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .lat_q(lat_q), .dir_q(dir_q), .ana_q(ana_q)
    );

    gpio_bus_fsm #(.WIDTH(WIDTH)) u_bus (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel),
        .pins_view(pins_sync & ~ana_q & keep_mask),
        .lat_view(lat_q & keep_mask),
        .dir_view(dir_q & keep_mask),
        .ana_view(ana_q),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    assign pad_out = lat_q;
    assign pad_oe  = ~dir_q & keep_mask;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
    parameter int WIDTH    = 8,
    parameter int OSC_PINS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [WIDTH-1:0] wdata,
    input logic             osc_claim,
    input logic             rd_valid,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);
    localparam int LOW_PINS = WIDTH - OSC_PINS;

    p_valid_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_idle_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> pad_out == $past(wdata));
    p_pins_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> pad_out == $past(wdata));
    p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> pad_oe[LOW_PINS-1:0] == ~$past(wdata[LOW_PINS-1:0]));
    p_oe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd2) |=> $stable(pad_oe[LOW_PINS-1:0]));
    p_osc_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_claim |-> pad_oe[WIDTH-1:LOW_PINS] == '0);
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.WIDTH(WIDTH), .OSC_PINS(OSC_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .osc_claim(osc_claim), .rd_valid(rd_valid),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, osc_claim = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00, pad_in = 8'h00;
    logic [7:0] rdata, pad_out, pad_oe;
    logic       rd_valid;
    int         n_chk = 0, n_fail = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .osc_claim(osc_claim),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        check("R8 valid", {7'd0, rd_valid}, 8'h01);
    endtask

    function automatic logic [7:0] osc_keep(input logic c);
        return c ? 8'h3F : 8'hFF;
    endfunction

    initial begin
        logic [7:0] rv;
        logic [7:0] anas [6] = '{8'h00, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h3F};
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset defaults
        check("R1 oe", pad_oe, 8'h00);
        check("R1 valid idle", {7'd0, rd_valid}, 8'h00);
        bus_read(2'd2, rv); check("R1 dir", rv, 8'hFF);
        bus_read(2'd1, rv); check("R1 latch", rv, 8'h00);
        bus_read(2'd3, rv); check("R1 ansel", rv, 8'h3F);
        bus_read(2'd0, rv); check("R1 R6 pins", rv, 8'hFF & ~8'h3F);
        @(negedge clk);
        check("R8 valid drops", {7'd0, rd_valid}, 8'h00);

        // R4 and R7 direction sweep
        for (int c = 0; c < 2; c++) begin
            osc_claim = c[0];
            for (int v = 0; v < 256; v++) begin
                bus_write(2'd2, 8'(v));
                check(c ? "R7 oe" : "R4 oe", pad_oe, ~8'(v) & osc_keep(c[0]));
                if (v % 17 == 0) begin
                    bus_read(2'd2, rv);
                    check(c ? "R7 dir read" : "R4 dir read", rv, 8'(v) & osc_keep(c[0]));
                end
            end
        end
        osc_claim = 1'b0;

        // R2 latch sweep, R3 pin-register write
        bus_write(2'd3, 8'h00);
        pad_in = 8'h5A;
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd1, 8'(v));
            check("R2 pad_out", pad_out, 8'(v));
            bus_read(2'd1, rv); check("R2 latch read", rv, 8'(v));
            if (v % 16 == 3) begin
                bus_write(2'd0, ~8'(v));
                check("R3 pad_out", pad_out, ~8'(v));
                bus_read(2'd1, rv); check("R3 latch read", rv, ~8'(v));
                bus_read(2'd0, rv); check("R3 pins not latch", rv, 8'h5A);
            end
        end

        // R5 R6 R9 pin-level reads under analog masks and osc claim
        for (int k = 0; k < 6; k++) begin
            bus_write(2'd3, anas[k]);
            bus_read(2'd3, rv); check("R9 ansel read", rv, anas[k]);
            for (int v = 0; v < 256; v += 3) begin
                osc_claim = v[1];
                pad_in = 8'(v);
                repeat (2) @(negedge clk);
                bus_read(2'd0, rv);
                check("R6 R7 pins", rv, 8'(v) & ~anas[k] & osc_keep(v[1]));
            end
        end
        osc_claim = 1'b0;

        // R5 synchronizer window
        bus_write(2'd3, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hA5;
        @(negedge clk);
        bus_read(2'd0, rv); check("R5 old level", rv, 8'h00);
        bus_read(2'd0, rv); check("R5 new level", rv, 8'hA5);

        // R10 stored bits survive osc claim
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'h0F);
        osc_claim = 1'b1;
        @(negedge clk);
        check("R7 oe claimed", pad_oe, 8'h30);
        bus_read(2'd1, rv); check("R7 latch masked", rv, 8'h3F);
        osc_claim = 1'b0;
        @(negedge clk);
        check("R10 oe restored", pad_oe, 8'hF0);
        bus_read(2'd1, rv); check("R10 latch restored", rv, 8'hFF);
        bus_read(2'd2, rv); check("R10 dir restored", rv, 8'h0F);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule